// File: doc/BRIEF.md
# Fractional Multiply-Divide Unit

This block is a sequential multiplier and divider for signed fixed-point fractions of `W` bits (40 by default). A value `x` held in a register stands for the fraction `x / 2^(W-1)`, so its range runs from -1 up to one step below +1. The unit owns two result registers: an accumulator (`ac`) and a multiplier-quotient register (`mq`). A caller supplies a memory operand, picks an operation and pulses `start`.

A load operation places the operand in `mq`. A multiply forms the product of the operand and `mq` one multiplier bit per cycle. It leaves the high half of the double-length product, with its sign, in `ac`. It leaves the low half in `mq` with a zero sign bit appended, so that `ac * 2^(W-1) + mq` equals the product. A divide divides `ac` by the operand with restoring iteration on magnitudes. The truncated quotient goes to `mq` and the remainder to `ac`. A divide whose quotient could not be a fraction is refused up front and flagged.

Top module: `frac_muldiv`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ac`, `mq`, `busy`, `done` and `ovf` are all zero.
- R2: A `start` with `op` = 2'b00 (load) while idle writes `operand` into `mq` at that clock edge and leaves `ac` unchanged. `done` is high for the following cycle and `busy` never rises.
- R3: A `start` with `op` = 2'b01 (multiply) while idle sets `busy` for exactly `W` cycles. During those cycles `ac` reads zero. Then `busy` falls and `done` is high for one cycle. At that point, for the integer product P of operand and old `mq`, `ac` = P[2W-2:W-1] and `mq` = {1'b0, P[W-2:0]}, so the `mq` sign bit is zero.
- R4: After k of the W multiply cycles (1 <= k < W), the top k bits of `mq` equal the low k bits of the final product.
- R5: Multiplying -1 by -1 (both registers at the most negative code) wraps modulo 2^(2W-1). `ac` becomes the most negative code and `mq` becomes zero.
- R6: A `start` with `op` = 2'b10 (divide) while idle and with |operand| > |ac| sets `busy` for W-1 cycles. Then `done` pulses with `ovf` low. `mq` holds the quotient `(ac*2^(W-1))/operand`, truncated toward zero. `ac` holds the remainder, which carries the dividend's sign.
- R7: A divide with |operand| <= |ac| (a zero divisor included) keeps `busy` low, raises `ovf` and pulses `done` in the next cycle, and leaves `ac` and `mq` unchanged.
- R8: `ovf` stays high until the next accepted `start` of a load, multiply or divide, which clears it.
- R9: A `start` while `busy` is high is ignored. The running operation's result and its single `done` pulse are unaffected.
- R10: A `start` with `op` = 2'b11 has no effect: no `done`, and `ac`, `mq` and `ovf` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled while idle |
| op | input | 2 | 00 load mq, 01 multiply, 10 divide, 11 none |
| operand | input | W | Memory operand, signed fraction |
| ac | output | W | Accumulator |
| mq | output | W | Multiplier-quotient register |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Last divide was refused |

## Verification
The bench builds the unit with `W` = 6. At that width every one of the 4096 operand pairs fits in the run, for multiply and for divide, so both extreme codes (-1 and the largest positive fraction) are covered in every combination. Each dividend is placed in `ac` by multiplying by -1. This also exercises the wrap of -1 times -1. Quotient, remainder, split product and the partial product bits in `mq` are computed with plain integer arithmetic in the bench.

// File: rtl/frac_muldiv.sv
module frac_muldiv #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] operand,
  output logic [W-1:0] ac,
  output logic [W-1:0] mq,
  output logic         busy,
  output logic         done,
  output logic         ovf
);
  localparam int CW = $clog2(W + 1);
  localparam logic [1:0] OP_LD  = 2'b00;
  localparam logic [1:0] OP_MUL = 2'b01;
  localparam logic [1:0] OP_DIV = 2'b10;

  logic [W+1:0]  pa;
  logic [W-1:0]  m;
  logic [CW-1:0] cnt;
  logic [1:0]    op_q;
  logic          qneg, rneg;

  logic          last_mul, last_div, accept, ge, div_refuse;
  logic [W+1:0]  m_ext, addend, msum, mpa_n, dsh, ddif, drem_n;
  logic [W-1:0]  mmq_n, dq_n, opd_mag, ac_mag, mul_ac, mul_mq, div_q, div_r;

  assign last_mul = (cnt == CW'(W - 1));
  assign last_div = (cnt == CW'(W - 2));
  assign accept   = !busy && start && (op != 2'b11);

  assign m_ext  = {{2{m[W-1]}}, m};
  assign addend = !mq[0] ? '0 : (last_mul ? -m_ext : m_ext);
  assign msum   = pa + addend;
  assign mpa_n  = {msum[W+1], msum[W+1:1]};
  assign mmq_n  = {msum[0], mq[W-1:1]};
  assign mul_ac = {mpa_n[W-2:0], mmq_n[W-1]};
  assign mul_mq = {1'b0, mmq_n[W-2:0]};

  assign opd_mag    = operand[W-1] ? -operand : operand;
  assign ac_mag     = ac[W-1] ? -ac : ac;
  assign div_refuse = (opd_mag <= ac_mag);

  assign dsh    = {pa[W:0], 1'b0};
  assign ddif   = dsh - {2'b00, m};
  assign ge     = !ddif[W+1];
  assign drem_n = ge ? ddif : dsh;
  assign dq_n   = {mq[W-2:0], ge};
  assign div_q  = qneg ? -dq_n : dq_n;
  assign div_r  = rneg ? -drem_n[W-1:0] : drem_n[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac   <= '0;
      mq   <= '0;
      pa   <= '0;
      m    <= '0;
      cnt  <= '0;
      op_q <= OP_LD;
      qneg <= 1'b0;
      rneg <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q <= op;
        ovf  <= 1'b0;
        case (op)
          OP_LD: begin
            mq   <= operand;
            done <= 1'b1;
          end
          OP_MUL: begin
            m    <= operand;
            pa   <= '0;
            ac   <= '0;
            cnt  <= '0;
            busy <= 1'b1;
          end
          default: begin
            if (div_refuse) begin
              ovf  <= 1'b1;
              done <= 1'b1;
            end else begin
              m    <= opd_mag;
              pa   <= {2'b00, ac_mag};
              mq   <= '0;
              qneg <= ac[W-1] ^ operand[W-1];
              rneg <= ac[W-1];
              cnt  <= '0;
              busy <= 1'b1;
            end
          end
        endcase
      end else if (busy) begin
        cnt <= cnt + CW'(1);
        if (op_q == OP_MUL) begin
          pa <= mpa_n;
          if (last_mul) begin
            ac   <= mul_ac;
            mq   <= mul_mq;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            mq <= mmq_n;
          end
        end else begin
          pa <= drem_n;
          if (last_div) begin
            ac   <= div_r;
            mq   <= div_q;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            mq <= dq_n;
          end
        end
      end
    end
  end

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R3
  mul_low_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_MUL) |-> !mq[W-1]);

  // R3
  mul_ac_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_MUL) |-> (ac == '0));

  // R7
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> ($stable(ac) && $stable(mq) && !busy));

  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> done);

  // R9
  busy_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && op != 2'b11)) |=> ($stable(ac) && $stable(mq) && !done));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CW'(W)));
endmodule

// File: tb/frac_muldiv_bench.sv
module frac_muldiv_bench;
  localparam int W    = 6;
  localparam int H    = 1 << (W - 1);
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [W-1:0] operand = '0;
  logic [W-1:0] ac, mq;
  logic busy, done, ovf;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  frac_muldiv #(.W(W)) u_frac_muldiv (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
    .ac(ac), .mq(mq), .busy(busy), .done(done), .ovf(ovf)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic issue(input logic [1:0] o, input int v);
    @(negedge clk);
    op = o;
    operand = v[W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic load_mq(input int y);
    int ac0;
    ac0 = int'(ac);
    issue(2'b00, y);
    check(int'(mq) == (y & MASK), "R2 mq", int'(mq), y & MASK);
    check(done && !busy && int'(ac) == ac0, "R2 done/ac", int'(ac), ac0);
    check(!ovf, "R8 cleared", ovf, 0);
  endtask

  task automatic run_mul(input int x, input int y);
    int p, exp_ac, exp_mq;
    load_mq(y);
    issue(2'b01, x);
    p = x * y;
    exp_ac = (p >>> (W - 1)) & MASK;
    exp_mq = p & (H - 1);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      if (k < W) begin
        check(busy && !done && ac == '0, "R3 busy", busy, 1);
        check((int'(mq) >> (W - k)) == (p & ((1 << k) - 1)), "R4 partial",
              int'(mq) >> (W - k), p & ((1 << k) - 1));
      end else begin
        check(!busy && done, "R3 done", done, 1);
        check(int'(ac) == exp_ac, (x == -H && y == -H) ? "R5 ac" : "R3 ac", int'(ac), exp_ac);
        check(int'(mq) == exp_mq, (x == -H && y == -H) ? "R5 mq" : "R3 mq", int'(mq), exp_mq);
      end
    end
  endtask

  task automatic run_div(input int x, input int y);
    int mq0, n, q, r;
    run_mul(-x, -H);
    check(int'(ac) == (x & MASK), "R3 ac via -1", int'(ac), x & MASK);
    mq0 = int'(mq);
    issue(2'b10, y);
    if (iabs(y) <= iabs(x)) begin
      check(done && ovf && !busy, "R7 flag", ovf, 1);
      check(int'(ac) == (x & MASK) && int'(mq) == mq0, "R7 hold", int'(mq), mq0);
      @(negedge clk);
      check(ovf && !done, "R8 persist", ovf, 1);
    end else begin
      n = x * H;
      q = n / y;
      r = n % y;
      for (int k = 1; k < W; k++) begin
        @(negedge clk);
        if (k < W - 1) check(busy && !done, "R6 busy", busy, 1);
      end
      check(done && !busy && !ovf, "R6 done", done, 1);
      check(int'(mq) == (q & MASK), "R6 quotient", int'(mq), q & MASK);
      check(int'(ac) == (r & MASK), "R6 remainder", int'(ac), r & MASK);
    end
  endtask

  initial begin
    int ac0, mq0;
    #1;
    check(ac == '0 && mq == '0 && !busy && !done && !ovf, "R1 in reset", int'(ac), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ac == '0 && mq == '0 && !busy && !done && !ovf, "R1 after reset", int'(mq), 0);

    run_mul(H - 1, H - 1);
    run_mul(-H, -H);
    @(negedge clk);
    check(!done, "R3 single pulse", done, 0);

    load_mq(7);
    issue(2'b01, 9);
    op = 2'b00;
    operand = 6'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W - 1) @(negedge clk);
    check(done && int'(ac) == 1 && int'(mq) == 31, "R9 result", int'(mq), 31);
    @(negedge clk);
    check(!done && int'(mq) == 31, "R9 no extra", done, 0);

    run_div(10, 3);
    ac0 = int'(ac);
    mq0 = int'(mq);
    issue(2'b11, 5);
    check(!done && !busy && ovf, "R10 no effect", done, 0);
    check(int'(ac) == ac0 && int'(mq) == mq0, "R10 regs", int'(ac), ac0);
    run_div(5, 0);

    for (int x = -H; x < H; x++)
      for (int y = -H; y < H; y++)
        run_mul(x, y);
    for (int x = -H; x < H; x++)
      for (int y = -H; y < H; y++)
        run_div(x, y);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule